// File: doc/BRIEF.md
# Banked GPIO Interrupt Detector

This block watches up to 128 already-synchronized GPIO pin inputs (93 by default) and turns pin activity into latched interrupt events. The pins are split into banks of 32. Each pin is configured on its own: it can fire on a rising edge, a falling edge, or both, or it can fire on an active-high or active-low level. Every detected event sets a sticky per-pin status bit, and software clears that bit by writing a one to it.

A single interrupt line is raised when any status bit is set whose pin is not masked. A global hold bit keeps the line low while software works through the banks, and events still latch during that time. When the pin count is not a multiple of 32, the upper bits of the last bank have no pin behind them and never report an event.

Software reaches the block through a flat 32-bit register port. Writes take effect on the clock edge. Reads are combinational from the current address.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every status bit, the hold bit and `irq_out` are 0. The rise-disable, fall-disable, level-disable and interrupt-mask registers read all ones. The mode and level-polarity registers read 0.
- R2: When a pin's mode bit is 0 and its rise-disable bit is 0, a low-to-high change of the pin (compared with its value one clock earlier) sets its status bit on that clock edge.
- R3: When a pin's mode bit is 0 and its fall-disable bit is 0, a high-to-low change of the pin sets its status bit.
- R4: A rise-disable or fall-disable bit of 1 suppresses that edge. A mode bit of 1 disables both edge paths for the pin.
- R5: When a pin's mode bit is 1 and its level-disable bit is 0, the status bit is set on every clock while the pin is at its active level. A polarity bit of 1 makes low the active level and 0 makes high the active level. A level-disable bit of 1 turns the level path off.
- R6: While an enabled level stays active, a write-1 clear of that status bit does not leave it cleared.
- R7: Writing the status register clears each bit written as 1 and leaves bits written as 0 unchanged. Status bits otherwise stay set. A new event in the same cycle as a clear of the same bit leaves the bit set.
- R8: Status bits above the last valid pin in the final bank are never set and read as 0, whatever the configuration.
- R9: `irq_out` is a registered output. It is 1 in the cycle after some status bit is set with interrupt-mask bit 0 while hold is 0, and it is 0 otherwise.
- R10: While the hold bit (bit 16 of the global register) is 1, `irq_out` stays 0 and events still latch into status.
- R11: The address bits [7:4] select the function: 0 rise-disable, 1 fall-disable, 2 mode, 3 level polarity, 4 level disable, 5 interrupt mask, 6 status, 7 global. For functions 0 to 6, bits [3:2] select the bank and pin n maps to bank n/32, bit n%32. The global register sits only at bank 0. An access with bits [1:0] nonzero, with bits above 7 nonzero, or to a bank that does not exist writes nothing and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and detection clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the current address |
| pin_in | input | NUM_PINS | Synchronized pin levels |
| irq_out | output | 1 | Combined registered interrupt request |

## Verification
The bench checks the timing of a clear that lands in the same cycle as a fresh edge on the same bit. A design that let the clear win would lose that event without any trace. It checks that a level source clears and then sets again at once while its level stays active. A design that treated level mode as a single-shot latch would leave the line quiet while the pin still demands service. It also checks the three missing pins of the last bank under an active-low configuration, where a missing-pin filter would let phantom events appear. Finally it checks hold and the one-cycle lag of `irq_out`: an off-by-one or a hold that also blocked latching would show up as a mismatch against the cycle model, which the bench runs through long random stretches.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int unsigned WORD_W     = 32;
  localparam int unsigned BANK_SEL_W = 2;
  localparam int unsigned HOLD_BIT   = 16;

  typedef enum logic [3:0] {
    FN_RISE_OFF = 4'h0,
    FN_FALL_OFF = 4'h1,
    FN_MODE_LVL = 4'h2,
    FN_LVL_LOW  = 4'h3,
    FN_LVL_OFF  = 4'h4,
    FN_IRQ_MASK = 4'h5,
    FN_STATUS   = 4'h6,
    FN_GLOBAL   = 4'h7
  } reg_fn_e;

  // Bits of a bank that have a real pin behind them.
  function automatic logic [WORD_W-1:0] bank_valid_mask(int bank, int num_pins);
    logic [WORD_W-1:0] m;
    for (int i = 0; i < WORD_W; i++) begin
      m[i] = ((bank * WORD_W + i) < num_pins);
    end
    return m;
  endfunction

  // Edge hits for one bank: current vs previous sample, gated by disable bits.
  function automatic logic [WORD_W-1:0] edge_hits(
    logic [WORD_W-1:0] cur, logic [WORD_W-1:0] prev,
    logic [WORD_W-1:0] rise_off, logic [WORD_W-1:0] fall_off);
    return (cur & ~prev & ~rise_off) | (~cur & prev & ~fall_off);
  endfunction

  // Level hits: polarity bit inverts the pin, disable bit kills the path.
  function automatic logic [WORD_W-1:0] level_hits(
    logic [WORD_W-1:0] cur, logic [WORD_W-1:0] low_act, logic [WORD_W-1:0] lvl_off);
    return (cur ^ low_act) & ~lvl_off;
  endfunction

endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 3
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  reg_fn_e                            fn,
  input  logic [BANK_SEL_W-1:0]              bank,
  input  logic [WORD_W-1:0]                  wdata,
  output logic [NUM_BANKS-1:0][WORD_W-1:0]   rise_off,
  output logic [NUM_BANKS-1:0][WORD_W-1:0]   fall_off,
  output logic [NUM_BANKS-1:0][WORD_W-1:0]   mode_lvl,
  output logic [NUM_BANKS-1:0][WORD_W-1:0]   lvl_low,
  output logic [NUM_BANKS-1:0][WORD_W-1:0]   lvl_off,
  output logic [NUM_BANKS-1:0][WORD_W-1:0]   irq_mask,
  output logic                               hold,
  output logic [WORD_W-1:0]                  rdata
);

  logic bank_ok;
  assign bank_ok = (int'(bank) < NUM_BANKS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_off <= '1;
      fall_off <= '1;
      mode_lvl <= '0;
      lvl_low  <= '0;
      lvl_off  <= '1;
      irq_mask <= '1;
      hold     <= 1'b0;
    end else if (wr_en) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (int'(bank) == b) begin
          case (fn)
            FN_RISE_OFF: rise_off[b] <= wdata;
            FN_FALL_OFF: fall_off[b] <= wdata;
            FN_MODE_LVL: mode_lvl[b] <= wdata;
            FN_LVL_LOW:  lvl_low[b]  <= wdata;
            FN_LVL_OFF:  lvl_off[b]  <= wdata;
            FN_IRQ_MASK: irq_mask[b] <= wdata;
            default: ;
          endcase
        end
      end
      if (fn == FN_GLOBAL && bank == '0) begin
        hold <= wdata[HOLD_BIT];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (fn == FN_GLOBAL) begin
      if (bank == '0) rdata[HOLD_BIT] = hold;
    end else if (bank_ok) begin
      case (fn)
        FN_RISE_OFF: rdata = rise_off[bank];
        FN_FALL_OFF: rdata = fall_off[bank];
        FN_MODE_LVL: rdata = mode_lvl[bank];
        FN_LVL_LOW:  rdata = lvl_low[bank];
        FN_LVL_OFF:  rdata = lvl_off[bank];
        FN_IRQ_MASK: rdata = irq_mask[bank];
        default:     rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter logic [WORD_W-1:0] VALID = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] pin,
  input  logic [WORD_W-1:0] rise_off,
  input  logic [WORD_W-1:0] fall_off,
  input  logic [WORD_W-1:0] mode_lvl,
  input  logic [WORD_W-1:0] lvl_low,
  input  logic [WORD_W-1:0] lvl_off,
  input  logic [WORD_W-1:0] clr,
  output logic [WORD_W-1:0] evt,
  output logic [WORD_W-1:0] status
);

  logic [WORD_W-1:0] prev_q;
  logic [WORD_W-1:0] status_q;
  logic [WORD_W-1:0] edge_evt;
  logic [WORD_W-1:0] level_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pin;
  end

  assign edge_evt  = edge_hits(pin, prev_q, rise_off, fall_off) & ~mode_lvl;
  assign level_evt = level_hits(pin, lvl_low, lvl_off) & mode_lvl;
  assign evt       = (edge_evt | level_evt) & VALID;

  // Set dominates clear: the event term is OR-ed after the clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= ((status_q & ~clr) | evt) & VALID;
  end

  assign status = status_q;

endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
  parameter int unsigned W = 96
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] status,
  input  logic [W-1:0] mask,
  input  logic         hold,
  output logic         pending,
  output logic         irq
);

  assign pending = |(status & ~mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= pending & ~hold;
  end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 93,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic [WORD_W-1:0]   reg_wdata,
  output logic [WORD_W-1:0]   reg_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic                irq_out
);

  localparam int unsigned NUM_BANKS = (NUM_PINS + WORD_W - 1) / WORD_W;
  localparam int unsigned PAD_W     = NUM_BANKS * WORD_W;

  // Address decode
  logic                  addr_ok;
  logic                  wr_ok;
  reg_fn_e               fn;
  logic [BANK_SEL_W-1:0] bank_idx;

  assign addr_ok  = (reg_addr[1:0] == 2'b00) && ((reg_addr >> 8) == '0);
  assign wr_ok    = reg_wr && addr_ok;
  assign fn       = reg_fn_e'(reg_addr[7:4]);
  assign bank_idx = reg_addr[3:2];

  logic [PAD_W-1:0] pin_pad;
  assign pin_pad = PAD_W'(pin_in);

  // Configuration
  logic [NUM_BANKS-1:0][WORD_W-1:0] rise_off, fall_off, mode_lvl;
  logic [NUM_BANKS-1:0][WORD_W-1:0] lvl_low, lvl_off, irq_mask;
  logic                             hold;
  logic [WORD_W-1:0]                cfg_rdata;

  gpio_irq_cfg #(.NUM_BANKS(NUM_BANKS)) cfg_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_ok),
    .fn       (fn),
    .bank     (bank_idx),
    .wdata    (reg_wdata),
    .rise_off (rise_off),
    .fall_off (fall_off),
    .mode_lvl (mode_lvl),
    .lvl_low  (lvl_low),
    .lvl_off  (lvl_off),
    .irq_mask (irq_mask),
    .hold     (hold),
    .rdata    (cfg_rdata)
  );

  // Per-bank detection and status
  logic [NUM_BANKS-1:0][WORD_W-1:0] status_all;
  logic [NUM_BANKS-1:0][WORD_W-1:0] evt_all;
  logic [NUM_BANKS-1:0][WORD_W-1:0] clr_all;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign clr_all[b] = (wr_ok && fn == FN_STATUS && int'(bank_idx) == b) ? reg_wdata : '0;

    gpio_irq_bank #(.VALID(bank_valid_mask(b, NUM_PINS))) bank_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin      (pin_pad[b*WORD_W +: WORD_W]),
      .rise_off (rise_off[b]),
      .fall_off (fall_off[b]),
      .mode_lvl (mode_lvl[b]),
      .lvl_low  (lvl_low[b]),
      .lvl_off  (lvl_off[b]),
      .clr      (clr_all[b]),
      .evt      (evt_all[b]),
      .status   (status_all[b])
    );
  end

  // Named flat views for the checker
  logic [PAD_W-1:0] status_flat, evt_flat, clr_flat, mask_flat;
  logic             irq_pending;
  assign status_flat = status_all;
  assign evt_flat    = evt_all;
  assign clr_flat    = clr_all;
  assign mask_flat   = irq_mask;

  gpio_irq_merge #(.W(PAD_W)) merge_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .status  (status_flat),
    .mask    (mask_flat),
    .hold    (hold),
    .pending (irq_pending),
    .irq     (irq_out)
  );

  // Read mux
  always_comb begin
    reg_rdata = '0;
    if (addr_ok) begin
      if (fn == FN_STATUS) begin
        if (int'(bank_idx) < NUM_BANKS) reg_rdata = status_all[bank_idx];
      end else begin
        reg_rdata = cfg_rdata;
      end
    end
  end

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int unsigned NUM_PINS = 93,
  parameter int unsigned PAD_W    = 96
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PAD_W-1:0] status_flat,
  input logic [PAD_W-1:0] evt_flat,
  input logic [PAD_W-1:0] clr_flat,
  input logic [PAD_W-1:0] mask_flat,
  input logic             hold,
  input logic             irq_out
);

  function automatic logic [PAD_W-1:0] real_pins();
    logic [PAD_W-1:0] m;
    for (int i = 0; i < PAD_W; i++) m[i] = (i < NUM_PINS);
    return m;
  endfunction

  localparam logic [PAD_W-1:0] REAL = real_pins();

  AST_PAD_STATUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (status_flat & ~REAL) == '0);  // R8

  AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_flat & $past(evt_flat)) == $past(evt_flat)));  // R7

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_flat & $past(clr_flat & ~evt_flat)) == '0));  // R7

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~status_flat & $past(status_flat & ~clr_flat)) == '0));  // R7

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && ((status_flat & ~mask_flat) != '0)) |=> irq_out);  // R9

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (hold || ((status_flat & ~mask_flat) == '0)) |=> !irq_out);  // R10

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NUM_PINS(NUM_PINS), .PAD_W(PAD_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .status_flat (status_flat),
  .evt_flat    (evt_flat),
  .clr_flat    (clr_flat),
  .mask_flat   (mask_flat),
  .hold        (hold),
  .irq_out     (irq_out)
);

// File: tb/gpio_irq_ctrl_tb_top.sv
module gpio_irq_ctrl_tb_top;

  localparam int NP = 93;
  localparam int NB = 3;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] pins = '0;
  logic          irq;

  always #2 clk = ~clk;

  gpio_irq_ctrl #(.NUM_PINS(NP), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wr(wr), .reg_wdata(wdata),
    .reg_rdata(rdata), .pin_in(pins), .irq_out(irq)
  );

  int errs = 0;
  int checks = 0;

  // Bench model: fn 0..5 config, status, hold, previous pins, irq
  logic [31:0]   m_reg [0:5][0:3];
  logic [31:0]   m_stat [0:3];
  logic          m_hold = 1'b0;
  logic [NP-1:0] m_prev = '0;
  logic          m_irq = 1'b0;
  logic [31:0]   last_rd;
  logic          last_irq;

  function automatic logic [7:0] A(int fn, int b);
    return {4'(fn), 2'(b), 2'b00};
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] a);
    int fn, b;
    fn = int'(a[7:4]);
    b  = int'(a[3:2]);
    if (a[1:0] != 2'b00) return 32'h0;
    if (fn == 7) return (b == 0) ? (32'(m_hold) << 16) : 32'h0;
    if (fn > 7 || b >= NB) return 32'h0;
    if (fn == 6) return m_stat[b];
    return m_reg[fn][b];
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int b = 0; b < 4; b++) begin
      m_reg[0][b] = '1; m_reg[1][b] = '1; m_reg[2][b] = '0;
      m_reg[3][b] = '0; m_reg[4][b] = '1; m_reg[5][b] = '1;
      m_stat[b] = '0;
    end
    m_hold = 1'b0; m_prev = '0; m_irq = 1'b0;
  endtask

  task automatic model_advance(logic [NP-1:0] p, logic w, logic [7:0] a, logic [31:0] d);
    logic [31:0] nst [0:3];
    logic n_irq;
    n_irq = 1'b0;
    for (int b = 0; b < 4; b++) begin
      nst[b] = '0;
      for (int i = 0; i < 32; i++) begin
        int n;
        logic pv, qv, ev, cl;
        n = b * 32 + i;
        if (n < NP) begin
          pv = p[n]; qv = m_prev[n]; ev = 1'b0;
          if (!m_reg[2][b][i]) begin
            if (pv && !qv && !m_reg[0][b][i]) ev = 1'b1;
            if (!pv && qv && !m_reg[1][b][i]) ev = 1'b1;
          end else if (!m_reg[4][b][i]) begin
            ev = m_reg[3][b][i] ? !pv : pv;
          end
          cl = w && (a == A(6, b)) && d[i];
          nst[b][i] = ev ? 1'b1 : (cl ? 1'b0 : m_stat[b][i]);
          if (m_stat[b][i] && !m_reg[5][b][i]) n_irq = 1'b1;
        end
      end
    end
    if (m_hold) n_irq = 1'b0;
    if (w && a[1:0] == 2'b00) begin
      if (int'(a[7:4]) <= 5 && int'(a[3:2]) < NB) m_reg[a[7:4]][a[3:2]] = d;
      if (a[7:4] == 4'd7 && a[3:2] == 2'd0) m_hold = d[16];
    end
    for (int b = 0; b < 4; b++) m_stat[b] = nst[b];
    m_prev = p;
    m_irq = n_irq;
  endtask

  // One cycle: drive at negedge, compare with model, then advance model at the edge.
  task automatic step(logic [NP-1:0] p, logic w, logic [7:0] a, logic [31:0] d, string tag);
    @(negedge clk);
    pins = p; wr = w; addr = a; wdata = d;
    #1;
    last_rd = rdata;
    last_irq = irq;
    check("R9 model irq", 32'(irq), 32'(m_irq));
    if (!w) check(tag, rdata, m_read(a));
    model_advance(p, w, a, d);
    @(posedge clk);
  endtask

  task automatic wr_reg(logic [7:0] a, logic [31:0] d);
    step(pins, 1'b1, a, d, "R11");
  endtask

  task automatic rd(logic [7:0] a, string tag, logic [31:0] exp);
    step(pins, 1'b0, a, 32'h0, tag);
    check(tag, last_rd, exp);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    errs++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [NP-1:0] p;
    void'($urandom(32'd24681));
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset values
    check("R1 irq", 32'(irq), 32'h0);
    for (int fn = 0; fn < 8; fn++) begin
      for (int b = 0; b < NB; b++) begin
        logic [31:0] e;
        e = (fn == 0 || fn == 1 || fn == 4 || fn == 5) ? 32'hFFFF_FFFF : 32'h0;
        if (fn == 7) e = 32'h0;
        rd(A(fn, b), "R1", e);
      end
    end

    // R2: rising edge on pin 0, R9 latency
    wr_reg(A(0, 0), ~32'h1);
    wr_reg(A(5, 0), ~32'h1);
    p = pins; p[0] = 1'b1;
    step(p, 1'b0, A(6, 0), 32'h0, "R2");
    rd(A(6, 0), "R2", 32'h1);
    check("R9 lag", 32'(last_irq), 32'h0);
    rd(A(6, 0), "R2", 32'h1);
    check("R9 raised", 32'(last_irq), 32'h1);

    // R7: write 0 keeps, write 1 clears, event beats clear
    wr_reg(A(6, 0), 32'h0);
    rd(A(6, 0), "R7 w0", 32'h1);
    wr_reg(A(6, 0), 32'h1);
    rd(A(6, 0), "R7 w1", 32'h0);
    p = pins; p[0] = 1'b0;
    step(p, 1'b0, A(6, 0), 32'h0, "R7");
    p[0] = 1'b1;
    step(p, 1'b1, A(6, 0), 32'h1, "R7");
    rd(A(6, 0), "R7 set wins", 32'h1);
    wr_reg(A(6, 0), 32'h1);

    // R3: falling edge on pin 33
    wr_reg(A(1, 1), ~32'h2);
    p = pins; p[33] = 1'b1;
    step(p, 1'b0, A(6, 1), 32'h0, "R3");
    rd(A(6, 1), "R3 rise ignored", 32'h0);
    p[33] = 1'b0;
    step(p, 1'b0, A(6, 1), 32'h0, "R3");
    rd(A(6, 1), "R3", 32'h2);

    // R4: disabled rise, and mode 1 blocks edges
    p = pins; p[5] = 1'b1;
    step(p, 1'b0, A(6, 0), 32'h0, "R4");
    rd(A(6, 0), "R4 rise off", 32'h0);
    wr_reg(A(2, 0), 32'h1);
    p = pins; p[0] = 1'b0;
    step(p, 1'b0, A(6, 0), 32'h0, "R4");
    p[0] = 1'b1;
    step(p, 1'b0, A(6, 0), 32'h0, "R4");
    rd(A(6, 0), "R4 mode", 32'h0);

    // R5: level low on pin 67, level high on pin 66
    wr_reg(A(2, 2), 32'h8);
    wr_reg(A(3, 2), 32'h8);
    wr_reg(A(4, 2), ~32'h8);
    rd(A(6, 2), "R5", 32'h0);
    rd(A(6, 2), "R5 low", 32'h8);
    wr_reg(A(2, 2), 32'hC);
    wr_reg(A(4, 2), ~32'hC);
    rd(A(6, 2), "R5 high idle", 32'h8);
    p = pins; p[66] = 1'b1;
    step(p, 1'b0, A(6, 2), 32'h0, "R5");
    rd(A(6, 2), "R5 high", 32'hC);
    // R6: clear does not stick while active
    wr_reg(A(6, 2), 32'hC);
    rd(A(6, 2), "R6", 32'hC);
    wr_reg(A(4, 2), 32'hFFFF_FFFF);
    wr_reg(A(6, 2), 32'hC);
    rd(A(6, 2), "R5 off", 32'h0);
    p = pins; p[66] = 1'b0;
    step(p, 1'b0, A(6, 2), 32'h0, "R5");

    // R8: missing pins of the last bank under active-low level
    wr_reg(A(2, 2), 32'hE000_0000);
    wr_reg(A(3, 2), 32'hE000_0000);
    wr_reg(A(4, 2), 32'h1FFF_FFFF);
    rd(A(6, 2), "R8", 32'h0);
    rd(A(6, 2), "R8", 32'h0);
    wr_reg(A(4, 2), 32'hFFFF_FFFF);

    // R10: hold blocks irq, status still latches
    wr_reg(A(7, 0), 32'h0001_0000);
    wr_reg(A(2, 0), 32'h0);
    wr_reg(A(6, 0), 32'hFFFF_FFFF);
    p = pins; p[0] = 1'b0;
    step(p, 1'b0, A(6, 0), 32'h0, "R10");
    p[0] = 1'b1;
    step(p, 1'b0, A(6, 0), 32'h0, "R10");
    rd(A(6, 0), "R10 latched", 32'h1);
    rd(A(7, 0), "R10 reg", 32'h0001_0000);
    check("R10 held", 32'(last_irq), 32'h0);
    wr_reg(A(7, 0), 32'h0);
    rd(A(6, 0), "R10", 32'h1);
    check("R10 still low", 32'(last_irq), 32'h0);
    rd(A(6, 0), "R10", 32'h1);
    check("R10 released", 32'(last_irq), 32'h1);

    // R11: address map
    wr_reg(A(0, 1), 32'hA5A5_0F0F);
    rd(A(0, 1), "R11", 32'hA5A5_0F0F);
    rd(A(0, 0), "R11", ~32'h1);
    rd(A(0, 1) | 8'h1, "R11 unaligned", 32'h0);
    rd(A(0, 3), "R11 no bank", 32'h0);
    step(pins, 1'b1, A(1, 0) | 8'h2, 32'h0, "R11");
    rd(A(1, 0), "R11 ignored", 32'hFFFF_FFFF);

    // Random stretch against the model
    for (int n = 0; n < 4000; n++) begin
      logic [95:0] flip;
      logic [7:0]  a;
      logic        w;
      flip = {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom}
           & {$urandom, $urandom, $urandom};
      p = pins ^ flip[NP-1:0];
      a = {4'($urandom % 8), 2'($urandom % 4), (($urandom % 16) == 0) ? 2'b01 : 2'b00};
      w = (($urandom % 5) < 2);
      step(p, w, a, $urandom, (a[7:4] == 4'd6) ? "R7 rand" : "R11 rand");
    end

    finish_run();
  end

endmodule